// File: doc/BRIEF.md
# Two-Channel Shared-Bus DMA Arbiter

Two DMA channels share one internal address and data bus, so only one of them may own a transfer slot at a time. This arbiter watches the two request lines, picks a winner when the bus is idle and holds a one-hot grant for that channel until the channel strobes completion. It also keeps a registered record of which channel finished most recently.

The choice between two policies comes from a single mode bit held in channel 0's control register. That register is loaded through a plain write port. When the bit is clear, which is the state after reset, the channel that finished last drops to the bottom of the order. When the bit is set, channel 0 always beats channel 1. The completion history is kept up to date in both modes, so a return to the rotating policy starts from what actually happened on the bus.

Each channel's request/grant pair acts as a valid/ready handshake. The request is the valid, and the grant is the ready, and it stays high for the whole transfer. A channel that is not granted is back-pressured, and it keeps its request up until it is granted. A request that drops while its grant is held has no effect, and the grant ends only on that channel's done strobe.

Top module: `dma_bus_arbiter`

## Requirements
- R1: At most one bit of `grant` is high in any cycle. A bit rises only in the cycle after a clock edge at which `grant` was all-zero and that channel's request was high.
- R2: With `cfg_mode` = 1 (fixed), when both channels request at an idle edge, channel 0 wins, so `grant` = 2'b01.
- R3: With `cfg_mode` = 0 (rotating), when both channels request at an idle edge, the channel that is not recorded in `last_ch` wins (`last_ch` = 1 gives 2'b01, and `last_ch` = 0 gives 2'b10).
- R4: After reset, `grant` = 2'b00, `last_ch` = 1 and the rotating policy is active.
- R5: A write with `cfg_wr_en` = 1 and `cfg_wr_sel` = 0 loads bit 14 of `cfg_wr_data` as the mode (1 = fixed, 0 = rotating). Writes with `cfg_wr_sel` = 1 and all other data bits leave the policy unchanged.
- R6: A grant stays high until the granted channel's `done` bit is high at a clock edge, and `grant` is 2'b00 after that edge. Dropped requests, a request from the other channel and a done strobe from the other channel do not change it.
- R7: At the edge that ends a transfer, `last_ch` takes the index of the channel that finished (0 or 1). This happens in both modes, and `last_ch` does not change at any other time.
- R8: A lone requester at an idle edge is granted whatever the mode.
- R9: A mode write made while a grant is held does not change that grant. It applies from the next arbitration onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 2 | Per-channel transfer request (valid) |
| done | input | 2 | Per-channel end-of-transfer strobe |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_sel | input | 1 | Channel whose control register is written (0 or 1) |
| cfg_wr_data | input | 32 | Control register write data; bit 14 is the policy bit |
| grant | output | 2 | One-hot bus grant (ready) |
| last_ch | output | 1 | Index of the channel that completed most recently |

## Verification
The grant appears one clock after an idle edge that samples a request. It clears at the same edge that samples the matching done bit, and `last_ch` changes at that edge too. A mode write takes effect at the edge that samples it, so it shapes only arbitrations that happen at later edges. The bench drives every input on the falling edge and checks each result at the following falling edge, which is half a cycle after the edge that produced it. Any hold or ignore check is sampled over several falling edges while the competing stimulus is still applied.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic {CH0 = 1'b0, CH1 = 1'b1} ch_id_t;
endpackage

// File: rtl/arb_ctrl_reg.sv
module arb_ctrl_reg #(
  parameter int CTRL_W   = 32,
  parameter int MODE_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              mode_fixed
);
  localparam int SEL_CH0 = 0;

  logic unused_bits;
  assign unused_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_fixed <= 1'b0;
    else if (wr_en && (wr_sel == SEL_CH0[0]))
      mode_fixed <= wr_data[MODE_BIT];
  end

  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_sel) |=> $stable(mode_fixed)); // R5
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import dma_arb_pkg::*;
(
  input  logic [NUM_CH-1:0] req,
  input  logic              mode_fixed,
  input  ch_id_t            last,
  output ch_id_t            pick
);
  always_comb begin
    if (req[0] && !req[1])
      pick = CH0;
    else if (req[1] && !req[0])
      pick = CH1;
    else if (mode_fixed)
      pick = CH0;
    else
      pick = (last == CH0) ? CH1 : CH0;
  end
endmodule

// File: rtl/arb_grant_ctl.sv
module arb_grant_ctl
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] done,
  input  ch_id_t            pick,
  input  logic              mode_fixed,
  output logic [NUM_CH-1:0] grant,
  output ch_id_t            last
);
  logic [NUM_CH-1:0] pick_oh;
  logic              idle;
  logic              finish;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign pick_oh[i] = (int'(pick) == i);
  end

  assign idle   = (grant == '0);
  assign finish = |(done & grant);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= '0;
      last  <= CH1;
    end else if (idle) begin
      if (|req) grant <= pick_oh;
    end else if (finish) begin
      grant <= '0;
      last  <= grant[1] ? CH1 : CH0;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R1
  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req == 2'b00) |=> grant == 2'b00); // R1
  AST_FIXED_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req == 2'b11 && mode_fixed) |=> grant == 2'b01); // R2
  AST_ROT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req == 2'b11 && !mode_fixed) |=>
      grant == (($past(last) == CH1) ? 2'b01 : 2'b10)); // R3
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !finish) |=> (grant == $past(grant)) && (last == $past(last))); // R6
  AST_LAST_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && finish) |=> (grant == 2'b00) && (last == ($past(grant[1]) ? CH1 : CH0))); // R7
  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $countones(req) == 1) |=> grant == $past(req)); // R8
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int CTRL_W   = 32,
  parameter int MODE_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req,
  input  logic [1:0]        done,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_sel,
  input  logic [CTRL_W-1:0] cfg_wr_data,
  output logic [1:0]        grant,
  output logic              last_ch
);
  logic   mode_fixed;
  ch_id_t pick;
  ch_id_t last;

  arb_ctrl_reg #(.CTRL_W(CTRL_W), .MODE_BIT(MODE_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
    .wr_data(cfg_wr_data), .mode_fixed(mode_fixed)
  );

  arb_pick u_pick (
    .req(req), .mode_fixed(mode_fixed), .last(last), .pick(pick)
  );

  arb_grant_ctl u_grant (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .pick(pick),
    .mode_fixed(mode_fixed), .grant(grant), .last(last)
  );

  assign last_ch = (last == CH1);

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 2'b00 && (done & grant) == 2'b00 && cfg_wr_en) |=> $stable(grant)); // R9
endmodule

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req = '0;
  logic [1:0]  done = '0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_wr_sel = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [1:0]  grant;
  logic        last_ch;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  dma_bus_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data), .grant(grant), .last_ch(last_ch)
  );

  // {fixed mode, req[1:0], expected grant[1:0]}; history from reset is last = 1
  localparam logic [4:0] VEC [9] = '{
    5'b0_11_01, 5'b0_11_10, 5'b0_10_10, 5'b0_11_01, 5'b1_11_01,
    5'b1_10_10, 5'b1_11_01, 5'b0_11_10, 5'b0_01_01
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_ctrl(logic sel, logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  task automatic arbitrate(logic [1:0] r, logic [1:0] exp_g, string tag);
    @(negedge clk);
    req = r;
    @(negedge clk);
    check(tag, grant, exp_g);
  endtask

  task automatic finish_xfer(string tag);
    logic [1:0] g;
    g = grant;
    req = '0; done = g;
    @(negedge clk);
    done = '0;
    check(tag, {grant, last_ch}, {2'b00, g[1]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset grant/last", {grant, last_ch}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 idle after reset", {grant, last_ch}, 3'b001);

    for (int i = 0; i < 9; i++) begin
      write_ctrl(1'b0, {17'd0, VEC[i][4], 14'd0});
      arbitrate(VEC[i][3:2], VEC[i][1:0], VEC[i][4] ? "R2/R8 vector grant" : "R3/R8 vector grant");
      finish_xfer("R7 vector completion");
    end
    // last_ch = 0, rotating

    // R5: channel 1 write with bit 14 is ignored; other ch0 bits ignored
    write_ctrl(1'b1, 32'h0000_4000);
    write_ctrl(1'b0, 32'hFFFF_BFFF);
    arbitrate(2'b11, 2'b10, "R5 policy still rotating");
    finish_xfer("R7 after R5");
    // last = 1

    // R6: hold against dropped req, other done, other req
    arbitrate(2'b01, 2'b01, "R8 lone ch0");
    req = 2'b10; done = 2'b10;
    repeat (3) begin
      @(negedge clk);
      check("R6 grant held", {grant, last_ch}, 3'b011);
    end
    done = 2'b00; req = 2'b00;
    @(negedge clk);
    check("R6 grant held, req dropped", grant, 2'b01);
    finish_xfer("R6 release on own done");

    // R9: mode write during transfer does not preempt
    arbitrate(2'b10, 2'b10, "R8 lone ch1");
    req = 2'b11;
    write_ctrl(1'b0, 32'h0000_4000);
    check("R9 no preempt", grant, 2'b10);
    finish_xfer("R7 after R9");
    // last = 1, fixed: ch0 wins; then with last = 0 fixed still ch0
    arbitrate(2'b11, 2'b01, "R9 fixed applied next");
    finish_xfer("R7 fixed mode updates last");
    arbitrate(2'b11, 2'b01, "R2 fixed again");
    finish_xfer("R7 fixed again");
    write_ctrl(1'b0, 32'h0);
    arbitrate(2'b11, 2'b10, "R3 rotate resumes from history");
    finish_xfer("R7 rotate resume");

    // R1: no request, no grant
    @(negedge clk);
    req = 2'b00;
    repeat (2) @(negedge clk);
    check("R1 idle without request", grant, 2'b00);

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule